// File: doc/BRIEF.md
# Three-Stage Pixel Pipeline Memory Scheduler

This block shares one pixel-wide, single-port external SRAM among three per-pixel processing stages that run in a fixed rotation. The stages are a smoothing stage (nominally 27 memory cycles: 25 reads, 2 writes), a feature stage for activity, Laplacian and label (19 cycles: 18 reads, 1 write), and an edge stage (10 cycles: 9 reads, 1 write). The feature stage reads the 5x5-smoothed image and the edge stage reads the 3x3-smoothed image. The scheduler gives the memory to one stage at a time. It starts that stage, waits for its done pulse and then hands over to the next stage. When the edge stage finishes, the scheduler moves on to the next pixel. After the last pixel it returns to pixel 0 and keeps running without end.

Each stage reads what earlier stages stored on earlier passes. For this reason the results of the first frame are complete only after three full passes over the image. After that, every pass delivers results for one more frame. The scheduler counts passes and raises a sticky valid flag once three have completed. Stages address memory by a region code and an offset within that region. The scheduler adds the base address of the region. Each region is PIX_COUNT words long, and its base address is a parameter.

The request side of each stage is a valid/ready port. Ready is high only for the stage that holds the grant. A stage whose ready is low must keep its request pending, because the scheduler stores nothing. Only the granted stage's request reaches the memory, and it does so in the same cycle.

Top module: `sram_stage_sched`

## Requirements
- R1: While reset is sampled high (synchronous, active high), the block returns to pixel 0 with the grant on stage 0. In the cycle after that edge it shows pix_idx=0, stg_req_ready=3'b001, stg_start=3'b001, frame_done=0 and results_valid=0.
- R2: Exactly one bit of stg_req_ready is high, and it marks the granted stage. The grant moves 0 to 1 to 2 to 0, one step per clock edge, and only at an edge where the granted stage's done bit is high. Done bits of stages that do not hold the grant have no effect.
- R3: In the cycle after the grant moves, and in the first cycle after reset, stg_start is high for the granted stage only. In every other cycle stg_start is zero.
- R4: pix_idx goes up by one at each edge where stage 2 holds the grant and raises done. Otherwise pix_idx holds.
- R5: When that advance happens at pixel PIX_COUNT-1, pix_idx goes to 0. frame_done is high for exactly that one cycle, the cycle in which pix_idx shows 0.
- R6: results_valid goes high in the same cycle as the third frame_done after reset. It then stays high until the next reset.
- R7: sram_en equals the granted stage's request valid. sram_we and sram_wdata come from the granted stage only. Requests from other stages have no effect on the memory port.
- R8: sram_addr equals the base address of the region plus the offset. The region codes are: 0 input, 1 smoothed 5x5, 2 smoothed 3x3, 3 label, 4 edge output. Codes 5 to 7 give sram_en=0 and sram_we=0.
- R9: A request that the granted stage presents in the same cycle as its done pulse is still forwarded to the memory in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_idx | output | PW | Current pixel index shared by all stages |
| stg_start | output | 3 | One-cycle start pulse, one bit per stage |
| stg_done | input | 3 | Done pulse from each stage |
| stg_req_valid | input | 3 | Memory request valid, one bit per stage |
| stg_req_ready | output | 3 | Grant and ready, one bit per stage |
| stg_req_we | input | 3 | Request is a write, per stage |
| stg_req_region | input | 9 | 3-bit region code per stage, stage 0 in the low bits |
| stg_req_off | input | 3*PW | Word offset within the region, per stage |
| stg_req_wdata | input | 3*DW | Write data, per stage |
| sram_en | output | 1 | Memory access strobe |
| sram_we | output | 1 | Memory write enable |
| sram_addr | output | ADDR_W | Memory address |
| sram_wdata | output | DW | Memory write data |
| frame_done | output | 1 | One-cycle pulse on each wrap to pixel 0 |
| results_valid | output | 1 | Sticky flag after three completed passes |

## Verification
Two things can happen at the same clock edge. The edge stage's final done can move the pixel counter, which may wrap the frame and raise results_valid. In the same cycle, that stage's final write may still be on the memory port. The bench stage models raise done together with a random request. The stage lengths range from one cycle, where start and done fall in the same cycle, up to the nominal 27/19/10 cycles. Spurious done pulses and invalid region codes are injected from stages that do not hold the grant. A behavioural reference model predicts every output in every cycle. It judges the forwarded address and data of the done cycle, and the frame wrap of that edge, as separate checks.

// File: rtl/sched_pkg.sv
package sched_pkg;
  localparam int NSTG  = 3;
  localparam int RGN_W = 3;
  typedef logic [1:0] stg_t;
  typedef enum logic [RGN_W-1:0] {
    RGN_INPUT   = 3'd0,
    RGN_SMOOTH5 = 3'd1,
    RGN_SMOOTH3 = 3'd2,
    RGN_LABEL   = 3'd3,
    RGN_EDGE    = 3'd4
  } rgn_e;
endpackage

// File: rtl/stage_rotor.sv
module stage_rotor
  import sched_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [NSTG-1:0] done,
  output stg_t            grant,
  output logic [NSTG-1:0] start,
  output logic            pass_end
);
  logic pend;
  logic take;

  assign take     = done[grant];
  assign pass_end = take && (grant == stg_t'(NSTG - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      grant <= '0;
      pend  <= 1'b1;
    end else begin
      pend <= take;
      if (take) grant <= (grant == stg_t'(NSTG - 1)) ? '0 : stg_t'(grant + 2'd1);
    end
  end

  always_comb begin
    start = '0;
    if (pend) start[grant] = 1'b1;
  end

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !done[grant] |=> $stable(grant));
  assert_step_R2: assert property (@(posedge clk) disable iff (rst)
    done[grant] |=> grant == (($past(grant) == stg_t'(NSTG - 1)) ? stg_t'(0) : stg_t'($past(grant) + 2'd1)));
  assert_start_after_move_R3: assert property (@(posedge clk) disable iff (rst)
    done[grant] |=> $onehot(start));
  assert_start_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    !done[grant] |=> start == '0);
endmodule

// File: rtl/pixel_frame_ctr.sv
module pixel_frame_ctr #(
  parameter int PIX_COUNT = 10000,
  parameter int PW        = 14,
  parameter int FRAMES_OK = 3,
  localparam int FW       = $clog2(FRAMES_OK + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  output logic [PW-1:0] pix,
  output logic          frame_done,
  output logic          results_valid
);
  localparam logic [PW-1:0] LAST = PW'(PIX_COUNT - 1);
  logic [FW-1:0] fcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      pix           <= '0;
      fcnt          <= '0;
      frame_done    <= 1'b0;
      results_valid <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      if (adv) begin
        if (pix == LAST) begin
          pix        <= '0;
          frame_done <= 1'b1;
          if (fcnt != FW'(FRAMES_OK)) fcnt <= fcnt + 1'b1;
          if (fcnt == FW'(FRAMES_OK - 1)) results_valid <= 1'b1;
        end else begin
          pix <= pix + 1'b1;
        end
      end
    end
  end

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(pix));
  assert_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    (adv && pix == LAST) |=> (pix == '0) && frame_done);
  assert_fd_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);
  assert_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    results_valid |=> results_valid);
  assert_rise_on_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(results_valid) |-> frame_done);
endmodule

// File: rtl/sram_port_mux.sv
module sram_port_mux
  import sched_pkg::*;
#(
  parameter int PW     = 14,
  parameter int ADDR_W = 16,
  parameter int DW     = 8,
  parameter logic [ADDR_W-1:0] BASE_INPUT   = '0,
  parameter logic [ADDR_W-1:0] BASE_SMOOTH5 = '0,
  parameter logic [ADDR_W-1:0] BASE_SMOOTH3 = '0,
  parameter logic [ADDR_W-1:0] BASE_LABEL   = '0,
  parameter logic [ADDR_W-1:0] BASE_EDGE    = '0
) (
  input  stg_t                 grant,
  input  logic [NSTG-1:0]      valid,
  input  logic [NSTG-1:0]      we,
  input  logic [NSTG*RGN_W-1:0] region,
  input  logic [NSTG*PW-1:0]   off,
  input  logic [NSTG*DW-1:0]   wdata,
  output logic [NSTG-1:0]      ready,
  output logic                 m_en,
  output logic                 m_we,
  output logic [ADDR_W-1:0]    m_addr,
  output logic [DW-1:0]        m_wdata
);
  logic [RGN_W-1:0]  sel_rgn;
  logic [PW-1:0]     sel_off;
  logic [ADDR_W-1:0] base;
  logic              rgn_ok;

  for (genvar i = 0; i < NSTG; i++) begin : g_ready
    assign ready[i] = (grant == stg_t'(i));
  end

  assign sel_rgn = region[grant*RGN_W +: RGN_W];
  assign sel_off = off[grant*PW +: PW];

  always_comb begin
    rgn_ok = 1'b1;
    case (sel_rgn)
      RGN_INPUT:   base = BASE_INPUT;
      RGN_SMOOTH5: base = BASE_SMOOTH5;
      RGN_SMOOTH3: base = BASE_SMOOTH3;
      RGN_LABEL:   base = BASE_LABEL;
      RGN_EDGE:    base = BASE_EDGE;
      default: begin
        base   = '0;
        rgn_ok = 1'b0;
      end
    endcase
  end

  assign m_en    = valid[grant] & rgn_ok;
  assign m_we    = m_en & we[grant];
  assign m_addr  = base + ADDR_W'(sel_off);
  assign m_wdata = wdata[grant*DW +: DW];
endmodule

// File: rtl/sram_stage_sched.sv
module sram_stage_sched
  import sched_pkg::*;
#(
  parameter int PIX_COUNT = 10000,
  parameter int ADDR_W    = 16,
  parameter int DW        = 8,
  parameter logic [ADDR_W-1:0] BASE_INPUT   = ADDR_W'(0),
  parameter logic [ADDR_W-1:0] BASE_SMOOTH5 = ADDR_W'(PIX_COUNT),
  parameter logic [ADDR_W-1:0] BASE_SMOOTH3 = ADDR_W'(2 * PIX_COUNT),
  parameter logic [ADDR_W-1:0] BASE_LABEL   = ADDR_W'(3 * PIX_COUNT),
  parameter logic [ADDR_W-1:0] BASE_EDGE    = ADDR_W'(4 * PIX_COUNT),
  localparam int PW = $clog2(PIX_COUNT)
) (
  input  logic                   clk,
  input  logic                   rst,
  output logic [PW-1:0]          pix_idx,
  output logic [2:0]             stg_start,
  input  logic [2:0]             stg_done,
  input  logic [2:0]             stg_req_valid,
  output logic [2:0]             stg_req_ready,
  input  logic [2:0]             stg_req_we,
  input  logic [8:0]             stg_req_region,
  input  logic [3*PW-1:0]        stg_req_off,
  input  logic [3*DW-1:0]        stg_req_wdata,
  output logic                   sram_en,
  output logic                   sram_we,
  output logic [ADDR_W-1:0]      sram_addr,
  output logic [DW-1:0]          sram_wdata,
  output logic                   frame_done,
  output logic                   results_valid
);
  stg_t grant;
  logic pass_end;

  stage_rotor u_rotor (
    .clk(clk), .rst(rst), .done(stg_done),
    .grant(grant), .start(stg_start), .pass_end(pass_end)
  );

  pixel_frame_ctr #(.PIX_COUNT(PIX_COUNT), .PW(PW), .FRAMES_OK(3)) u_ctr (
    .clk(clk), .rst(rst), .adv(pass_end),
    .pix(pix_idx), .frame_done(frame_done), .results_valid(results_valid)
  );

  sram_port_mux #(
    .PW(PW), .ADDR_W(ADDR_W), .DW(DW),
    .BASE_INPUT(BASE_INPUT), .BASE_SMOOTH5(BASE_SMOOTH5), .BASE_SMOOTH3(BASE_SMOOTH3),
    .BASE_LABEL(BASE_LABEL), .BASE_EDGE(BASE_EDGE)
  ) u_mux (
    .grant(grant), .valid(stg_req_valid), .we(stg_req_we), .region(stg_req_region),
    .off(stg_req_off), .wdata(stg_req_wdata), .ready(stg_req_ready),
    .m_en(sram_en), .m_we(sram_we), .m_addr(sram_addr), .m_wdata(sram_wdata)
  );

  assert_ready_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot(stg_req_ready));
  assert_only_granted_R7: assert property (@(posedge clk) disable iff (rst)
    ((stg_req_valid & stg_req_ready) == 3'b000) |-> !sram_en);
  assert_we_needs_en_R8: assert property (@(posedge clk) disable iff (rst)
    sram_we |-> sram_en);
  assert_start_is_granted_R3: assert property (@(posedge clk) disable iff (rst)
    (stg_start & ~stg_req_ready) == 3'b000);
endmodule

// File: tb/tb_sram_stage_sched.sv
`timescale 1ns/1ps
module tb_sram_stage_sched;
  localparam int P  = 6;
  localparam int AW = 16;
  localparam int DW = 8;
  localparam int PW = $clog2(P);
  localparam int NCYC = 8000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [PW-1:0] pix_idx;
  logic [2:0] stg_start, stg_req_ready;
  logic [2:0] stg_done = '0, stg_req_valid = '0, stg_req_we = '0;
  logic [8:0] stg_req_region = '0;
  logic [3*PW-1:0] stg_req_off = '0;
  logic [3*DW-1:0] stg_req_wdata = '0;
  logic sram_en, sram_we, frame_done, results_valid;
  logic [AW-1:0] sram_addr;
  logic [DW-1:0] sram_wdata;

  always #2.5 clk = ~clk;

  sram_stage_sched #(
    .PIX_COUNT(P), .ADDR_W(AW), .DW(DW),
    .BASE_INPUT(16'h1000), .BASE_SMOOTH5(16'h2000), .BASE_SMOOTH3(16'h3000),
    .BASE_LABEL(16'h4000), .BASE_EDGE(16'h5000)
  ) dut (.*);

  int n_chk = 0, n_fail = 0;
  int r_g = 0, r_pix = 0, r_fr = 0;
  bit r_pend = 1, r_fd = 0, r_rv = 0;

  // Behavioural reference: state after each edge
  always @(posedge clk) begin
    if (rst) begin
      r_g = 0; r_pend = 1; r_pix = 0; r_fr = 0; r_fd = 0; r_rv = 0;
    end else begin
      r_fd = 0;
      r_pend = stg_done[r_g];
      if (stg_done[r_g]) begin
        if (r_g == 2) begin
          r_g = 0;
          if (r_pix == P - 1) begin
            r_pix = 0; r_fd = 1;
            if (r_fr < 3) r_fr++;
            if (r_fr == 3) r_rv = 1;
          end else r_pix++;
        end else r_g++;
      end
    end
  end

  function automatic logic [AW-1:0] base_of(int rg);
    case (rg)
      0: return 16'h1000;
      1: return 16'h2000;
      2: return 16'h3000;
      3: return 16'h4000;
      default: return 16'h5000;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int rg;
    bit ok, en;
    if (rst) begin
      check("R1 pix after reset", 32'(pix_idx), 0);
      check("R1 ready after reset", 32'(stg_req_ready), 1);
      check("R1 start after reset", 32'(stg_start), 1);
      check("R1 frame_done after reset", 32'(frame_done), 0);
      check("R1 results_valid after reset", 32'(results_valid), 0);
    end
    check("R4 pix_idx", 32'(pix_idx), 32'(r_pix));
    check("R2 ready grant", 32'(stg_req_ready), 32'(1 << r_g));
    check("R3 start", 32'(stg_start), r_pend ? 32'(1 << r_g) : 0);
    check("R5 frame_done", 32'(frame_done), 32'(r_fd));
    check("R6 results_valid", 32'(results_valid), 32'(r_rv));
    rg = int'(stg_req_region[r_g*3 +: 3]);
    ok = rg < 5;
    en = stg_req_valid[r_g] && ok;
    if (stg_done[r_g]) check("R9 en on done cycle", 32'(sram_en), 32'(en));
    else               check("R7 en", 32'(sram_en), 32'(en));
    check("R8 we", 32'(sram_we), 32'(en && stg_req_we[r_g]));
    if (en) begin
      if (stg_done[r_g])
        check("R9 addr on done cycle", 32'(sram_addr), 32'(base_of(rg) + 16'(stg_req_off[r_g*PW +: PW])));
      else
        check("R8 addr", 32'(sram_addr), 32'(base_of(rg) + 16'(stg_req_off[r_g*PW +: PW])));
      if (stg_req_we[r_g]) check("R7 wdata", 32'(sram_wdata), 32'(stg_req_wdata[r_g*DW +: DW]));
    end
  endtask

  initial begin
    int left = 0;
    int len [3];
    bit spur;
    for (int cyc = 0; cyc < NCYC; cyc++) begin
      @(negedge clk);
      compare_all();
      rst = (cyc < 3) || (cyc >= 2000 && cyc < 2002);
      if (cyc < 2000)      begin len = '{3, 2, 1};   spur = 0; end
      else if (cyc < 4500) begin len = '{1, 1, 1};   spur = 1; end
      else                 begin len = '{27, 19, 10}; spur = 1; end
      if (r_pend) left = len[r_g];
      for (int i = 0; i < 3; i++) begin
        stg_req_valid[i] = ($urandom % 4) != 0;
        stg_req_we[i]    = $urandom % 2;
        stg_req_region[i*3 +: 3] = (($urandom % 8) < 6) ? 3'($urandom % 5) : 3'(5 + $urandom % 3);
        stg_req_off[i*PW +: PW]  = PW'($urandom % P);
        stg_req_wdata[i*DW +: DW] = DW'($urandom);
        stg_done[i] = spur && (i != r_g) && (($urandom % 3) == 0);
      end
      stg_done[r_g] = (left == 1);
      left--;
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule